// File: doc/BRIEF.md
# Delayed-Update Adaptive Bin Equalizer

This block is the filtering and adaptation core of a linear equalizer that works on frequency bins. Each cycle it receives one complex value per bin (`NBINS` bins) from a sliding transform, plus the same bins already divided by their power estimate. It multiplies each raw bin by the conjugate of a per-bin complex coefficient and adds the results in a registered binary tree. The sum is the equalizer output. A slicer onto {+1, −1} gives the detected symbol.

The error is the reference minus the output. The reference is either a supplied training symbol or the slicer's own decision. The error is sent to every bin at once. Each coefficient then moves by the normalized bin times the conjugate error, scaled by a power-of-two step size. The sample that produced the error is several cycles old. Accepting this adaptation delay lets the tree, the error and the update each sit behind their own registers, so no stage holds more than one multiply and one add.

The caller aligns the training symbol with the sample it goes with. Any decision delay of the channel is applied before the symbol reaches the block. All values are signed fixed point with `FRAC` fractional bits, so 1.0 = 2^FRAC.

Top module: `dle_equalizer`

## Requirements
- R1: After reset, every coefficient is zero, `out_valid` is 0 and both output parts are 0.
- R2: The output for a sample appears LAT = clog2(NBINS)+1 cycles after the sample is accepted. `out_valid` follows `in_valid` with the same latency. The output is the sum over bins of conj(C)·f. Each bin's real part (Cr·fr + Ci·fi) and imaginary part (Cr·fi − Ci·fr) is shifted right arithmetically by FRAC before the bins are summed.
- R3: When `train_en` is 1 for a sample, the reference is +1.0 if `train_sym` is 0 and −1.0 if it is 1, with an imaginary part of 0. The error is reference minus output. Each part of the error is saturated to DW bits.
- R4: When `train_en` is 0, the reference is the slicer decision: +1.0 if the output's real part is ≥ 0, otherwise −1.0. `det_sym` is 1 exactly when the output's real part is negative, so an output of 0 gives 0 (+1).
- R5: The update term is computed as follows. Real part: (Fr·er + Fi·ei). Imaginary part: (Fi·er − Fr·ei). Each is shifted right arithmetically by FRAC+MU_SHIFT and saturated to DW bits. The coefficients that filter the sample accepted at cycle s contain the updates of exactly those valid samples accepted at cycle s−(clog2(NBINS)+4) or earlier.
- R6: A sample accepted with `in_valid` 0 never changes any coefficient. This holds whatever bin, training and symbol values it carries.
- R7: The coefficient accumulation saturates at the DW-bit signed limits instead of wrapping.
- R8: Each output part is saturated to the DW-bit signed range after the bin sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies this cycle's sample |
| bin_re | input | NBINS*DW | Raw bin real parts, bin m at [m*DW +: DW] |
| bin_im | input | NBINS*DW | Raw bin imaginary parts |
| nbin_re | input | NBINS*DW | Power-normalized bin real parts |
| nbin_im | input | NBINS*DW | Power-normalized bin imaginary parts |
| train_en | input | 1 | 1 = training reference, 0 = decision-directed |
| train_sym | input | 1 | Training symbol: 0 = +1, 1 = −1 |
| out_valid | output | 1 | Qualifies the output and decision |
| eq_re | output | DW | Equalizer output, real part |
| eq_im | output | DW | Equalizer output, imaginary part |
| det_sym | output | 1 | Slicer decision: 0 = +1, 1 = −1 |

## Verification
The condition hardest to reach from the ports is the exact cycle at which an update lands relative to later samples. If that cycle is off by one, the outputs differ only slightly, and only after the coefficients have moved. The stimulus therefore mixes dense valid streams with sparse, irregular ones. Every output is compared against a reference that applies each update at its stated distance.

Invalid cycles carry large bin and normalized values, so a wrongly gated update would visibly corrupt later outputs. A final full-scale phase drives both the bin sum and the coefficients into their saturation limits.

// File: rtl/dle_pkg.sv
package dle_pkg;
   typedef enum logic {
      ADAPT_DECIDE = 1'b0,
      ADAPT_TRAIN  = 1'b1
   } adapt_mode_e;
endpackage

// File: rtl/dle_cmul.sv
// Registered conjugate multiply of one bin: conj(c) * x, scaled down by FRAC.
module dle_cmul #(
   parameter int DW   = 16,
   parameter int FRAC = 12,
   parameter int PW   = 2*DW+1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [DW-1:0] c_re,
   input  logic signed [DW-1:0] c_im,
   input  logic signed [DW-1:0] x_re,
   input  logic signed [DW-1:0] x_im,
   output logic signed [PW-1:0] p_re,
   output logic signed [PW-1:0] p_im
);
   logic signed [PW-1:0] cr, ci, xr, xi, sr, si;

   always_comb begin
      cr = PW'(c_re);
      ci = PW'(c_im);
      xr = PW'(x_re);
      xi = PW'(x_im);
      sr = cr*xr + ci*xi;
      si = cr*xi - ci*xr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_re <= '0;
         p_im <= '0;
      end else begin
         p_re <= sr >>> FRAC;
         p_im <= si >>> FRAC;
      end
   end
endmodule

// File: rtl/dle_sum_tree.sv
// Pipelined binary adder tree, one register per level, saturated result.
module dle_sum_tree #(
   parameter int NIN = 8,
   parameter int IW  = 33,
   parameter int OW  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [IW-1:0] leaf [NIN],
   output logic signed [OW-1:0] sum_o
);
   localparam int LV = $clog2(NIN);
   localparam int NP = 1 << LV;
   localparam int TW = IW + LV;
   localparam logic signed [TW-1:0] HI = TW'((longint'(1) <<< (OW-1)) - 1);
   localparam logic signed [TW-1:0] LO = -HI - TW'(1);

   if (NIN < 2) begin : g_bad_nin
      $error("dle_sum_tree needs at least two inputs");
   end

   for (genvar lv = 0; lv <= LV; lv++) begin : g_lv
      localparam int W = NP >> lv;
      logic signed [TW-1:0] s [W];
      if (lv == 0) begin : g_leaves
         for (genvar i = 0; i < NP; i++) begin : g_in
            if (i < NIN) begin : g_use
               assign s[i] = TW'(leaf[i]);
            end else begin : g_pad
               assign s[i] = '0;
            end
         end
      end else begin : g_add
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < W; i++) s[i] <= '0;
            end else begin
               for (int i = 0; i < W; i++) s[i] <= g_lv[lv-1].s[2*i] + g_lv[lv-1].s[2*i+1];
            end
         end
      end
   end

   logic signed [TW-1:0] root;
   assign root = g_lv[LV].s[0];

   always_comb begin
      if (root > HI)      sum_o = HI[OW-1:0];
      else if (root < LO) sum_o = LO[OW-1:0];
      else                sum_o = root[OW-1:0];
   end
endmodule

// File: rtl/dle_coef_cell.sv
// One bin's coefficient: aligns the normalized bin with the broadcast error,
// forms the scaled update, and accumulates with saturation.
module dle_coef_cell #(
   parameter int DW       = 16,
   parameter int FRAC     = 12,
   parameter int MU_SHIFT = 4,
   parameter int FDEPTH   = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [DW-1:0] nf_re,
   input  logic signed [DW-1:0] nf_im,
   input  logic signed [DW-1:0] err_re,
   input  logic signed [DW-1:0] err_im,
   input  logic                 err_v,
   output logic signed [DW-1:0] c_re,
   output logic signed [DW-1:0] c_im
);
   localparam int PW = 2*DW+1;
   localparam logic signed [PW-1:0] HI = PW'((longint'(1) <<< (DW-1)) - 1);
   localparam logic signed [PW-1:0] LO = -HI - PW'(1);
   localparam logic signed [DW-1:0] CMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] CMIN = {1'b1, {(DW-1){1'b0}}};

   logic signed [DW-1:0] fl_re [FDEPTH];
   logic signed [DW-1:0] fl_im [FDEPTH];
   logic signed [PW-1:0] fr, fi, er, ei, tr, ti;
   logic signed [DW-1:0] u_re, u_im, u_re_d, u_im_d;
   logic signed [DW:0]   a_re, a_im;
   logic                 upd_v;

   function automatic logic signed [DW-1:0] clip_wide(input logic signed [PW-1:0] v);
      if (v > HI)      return HI[DW-1:0];
      else if (v < LO) return LO[DW-1:0];
      return v[DW-1:0];
   endfunction

   function automatic logic signed [DW-1:0] clip_one(input logic signed [DW:0] v);
      if (v[DW] != v[DW-1]) return v[DW] ? CMIN : CMAX;
      return v[DW-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < FDEPTH; i++) begin
            fl_re[i] <= '0;
            fl_im[i] <= '0;
         end
      end else begin
         fl_re[0] <= nf_re;
         fl_im[0] <= nf_im;
         for (int i = 1; i < FDEPTH; i++) begin
            fl_re[i] <= fl_re[i-1];
            fl_im[i] <= fl_im[i-1];
         end
      end
   end

   always_comb begin
      fr   = PW'(fl_re[FDEPTH-1]);
      fi   = PW'(fl_im[FDEPTH-1]);
      er   = PW'(err_re);
      ei   = PW'(err_im);
      tr   = (fr*er + fi*ei) >>> (FRAC + MU_SHIFT);
      ti   = (fi*er - fr*ei) >>> (FRAC + MU_SHIFT);
      u_re = clip_wide(tr);
      u_im = clip_wide(ti);
      a_re = (DW+1)'(c_re) + (DW+1)'(u_re_d);
      a_im = (DW+1)'(c_im) + (DW+1)'(u_im_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         u_re_d <= '0;
         u_im_d <= '0;
         upd_v  <= 1'b0;
         c_re   <= '0;
         c_im   <= '0;
      end else begin
         u_re_d <= u_re;
         u_im_d <= u_im;
         upd_v  <= err_v;
         if (upd_v) begin
            c_re <= clip_one(a_re);
            c_im <= clip_one(a_im);
         end
      end
   end

   // R6: without a pending valid update the coefficient holds
   assert_coef_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_v |=> ($stable(c_re) && $stable(c_im)));
   // R7: a non-negative step never lowers the coefficient (no wrap)
   assert_coef_no_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_v && !u_re_d[DW-1]) |=> (c_re >= $past(c_re)));
   // R7: a negative step never raises the coefficient (no wrap)
   assert_coef_no_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_v && u_re_d[DW-1]) |=> (c_re <= $past(c_re)));
endmodule

// File: rtl/dle_equalizer.sv
module dle_equalizer
   import dle_pkg::*;
#(
   parameter int NBINS    = 8,
   parameter int DW       = 16,
   parameter int FRAC     = 12,
   parameter int MU_SHIFT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [NBINS*DW-1:0]   bin_re,
   input  logic [NBINS*DW-1:0]   bin_im,
   input  logic [NBINS*DW-1:0]   nbin_re,
   input  logic [NBINS*DW-1:0]   nbin_im,
   input  logic                  train_en,
   input  logic                  train_sym,
   output logic                  out_valid,
   output logic signed [DW-1:0]  eq_re,
   output logic signed [DW-1:0]  eq_im,
   output logic                  det_sym
);
   localparam int LV     = $clog2(NBINS);
   localparam int PW     = 2*DW+1;
   localparam int FDEPTH = LV + 2;
   localparam logic signed [DW:0]   REF_POS = (DW+1)'(1) <<< FRAC;
   localparam logic signed [DW:0]   REF_NEG = -REF_POS;
   localparam logic signed [DW-1:0] EMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] EMIN = {1'b1, {(DW-1){1'b0}}};

   if (NBINS < 2) begin : g_bad_bins
      $error("dle_equalizer needs at least two bins");
   end
   if (FRAC > DW-2) begin : g_bad_frac
      $error("dle_equalizer: FRAC must leave room for +/-1.0");
   end
   if (2*DW+1 > 64) begin : g_bad_dw
      $error("dle_equalizer: DW too wide");
   end

   logic signed [PW-1:0] prod_re [NBINS];
   logic signed [PW-1:0] prod_im [NBINS];
   logic signed [DW-1:0] err_re, err_im;
   logic                 err_v;

   for (genvar m = 0; m < NBINS; m++) begin : g_bin
      logic signed [DW-1:0] c_re, c_im;
      dle_cmul #(.DW(DW), .FRAC(FRAC), .PW(PW)) u_mul (
         .clk(clk), .rst_n(rst_n),
         .c_re(c_re), .c_im(c_im),
         .x_re(bin_re[m*DW +: DW]), .x_im(bin_im[m*DW +: DW]),
         .p_re(prod_re[m]), .p_im(prod_im[m]));
      dle_coef_cell #(.DW(DW), .FRAC(FRAC), .MU_SHIFT(MU_SHIFT), .FDEPTH(FDEPTH)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .nf_re(nbin_re[m*DW +: DW]), .nf_im(nbin_im[m*DW +: DW]),
         .err_re(err_re), .err_im(err_im), .err_v(err_v),
         .c_re(c_re), .c_im(c_im));
   end

   dle_sum_tree #(.NIN(NBINS), .IW(PW), .OW(DW)) u_tree_re (
      .clk(clk), .rst_n(rst_n), .leaf(prod_re), .sum_o(eq_re));
   dle_sum_tree #(.NIN(NBINS), .IW(PW), .OW(DW)) u_tree_im (
      .clk(clk), .rst_n(rst_n), .leaf(prod_im), .sum_o(eq_im));

   // side information travels with the data through product + tree stages
   logic [LV:0]  v_line;
   logic [LV:0]  sym_line;
   adapt_mode_e  mode_line [LV+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_line   <= '0;
         sym_line <= '0;
         for (int i = 0; i <= LV; i++) mode_line[i] <= ADAPT_DECIDE;
      end else begin
         v_line       <= {v_line[LV-1:0], in_valid};
         sym_line     <= {sym_line[LV-1:0], train_sym};
         mode_line[0] <= adapt_mode_e'(train_en);
         for (int i = 1; i <= LV; i++) mode_line[i] <= mode_line[i-1];
      end
   end

   assign out_valid = v_line[LV];
   assign det_sym   = eq_re[DW-1];

   function automatic logic signed [DW-1:0] clip_one(input logic signed [DW:0] v);
      if (v[DW] != v[DW-1]) return v[DW] ? EMIN : EMAX;
      return v[DW-1:0];
   endfunction

   logic signed [DW:0] ref_re, diff_re, diff_im;

   always_comb begin
      if (mode_line[LV] == ADAPT_TRAIN) ref_re = sym_line[LV] ? REF_NEG : REF_POS;
      else                              ref_re = det_sym      ? REF_NEG : REF_POS;
      diff_re = ref_re - (DW+1)'(eq_re);
      diff_im = -(DW+1)'(eq_im);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_re <= '0;
         err_im <= '0;
         err_v  <= 1'b0;
      end else begin
         err_re <= clip_one(diff_re);
         err_im <= clip_one(diff_im);
         err_v  <= out_valid;
      end
   end

   logic seen_in;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_in <= 1'b0;
      else if (in_valid) seen_in <= 1'b1;
   end

   // R2: a qualified output needs an accepted sample behind it
   assert_valid_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> seen_in);
   // R1: no update can be broadcast before an output was qualified
   assert_err_follows_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_v) |-> $past(out_valid));
endmodule

// File: tb/dle_equalizer_bench.sv
module dle_equalizer_bench;
   localparam int NB   = 8;
   localparam int DW   = 16;
   localparam int FRAC = 12;
   localparam int MU   = 4;
   localparam int LV   = 3;
   localparam int PER  = 10;
   localparam int NCYC = 1400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [NB*DW-1:0] bin_re = '0, bin_im = '0, nbin_re = '0, nbin_im = '0;
   logic train_en = 1'b0, train_sym = 1'b0;
   logic out_valid;
   logic signed [DW-1:0] eq_re, eq_im;
   logic det_sym;

   always #(PER/2) clk = ~clk;

   dle_equalizer #(.NBINS(NB), .DW(DW), .FRAC(FRAC), .MU_SHIFT(MU)) u_dle_equalizer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .bin_re(bin_re), .bin_im(bin_im), .nbin_re(nbin_re), .nbin_im(nbin_im),
      .train_en(train_en), .train_sym(train_sym),
      .out_valid(out_valid), .eq_re(eq_re), .eq_im(eq_im), .det_sym(det_sym));

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   longint cm_re [NB], cm_im [NB];
   longint y_re_h [NCYC], y_im_h [NCYC];
   bit     v_h [NCYC];
   longint u_re_h [NCYC][NB], u_im_h [NCYC][NB];
   longint fr [NB], fi [NB], gr [NB], gi [NB];

   function automatic longint sat(longint v);
      longint hi = (longint'(1) <<< (DW-1)) - 1;
      if (v > hi)      return hi;
      if (v < -hi - 1) return -hi - 1;
      return v;
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // reference behaviour at one clock edge k
   task automatic model_step(int k, bit v, bit tr, bit sym);
      longint yr = 0, yi = 0, rr, er, ei;
      for (int m = 0; m < NB; m++) begin
         yr += (cm_re[m]*fr[m] + cm_im[m]*fi[m]) >>> FRAC;
         yi += (cm_re[m]*fi[m] - cm_im[m]*fr[m]) >>> FRAC;
      end
      yr = sat(yr);
      yi = sat(yi);
      y_re_h[k] = yr;
      y_im_h[k] = yi;
      v_h[k]    = v;
      if (tr) rr = sym ? -(longint'(1) <<< FRAC) : (longint'(1) <<< FRAC);
      else    rr = (yr < 0) ? -(longint'(1) <<< FRAC) : (longint'(1) <<< FRAC);
      er = sat(rr - yr);
      ei = sat(-yi);
      for (int m = 0; m < NB; m++) begin
         u_re_h[k][m] = sat((gr[m]*er + gi[m]*ei) >>> (FRAC+MU));
         u_im_h[k][m] = sat((gi[m]*er - gr[m]*ei) >>> (FRAC+MU));
      end
      if (k >= LV+3 && v_h[k-LV-3]) begin
         for (int m = 0; m < NB; m++) begin
            cm_re[m] = sat(cm_re[m] + u_re_h[k-LV-3][m]);
            cm_im[m] = sat(cm_im[m] + u_im_h[k-LV-3][m]);
         end
      end
   endtask

   function automatic longint rnd(int a);
      return longint'(int'($urandom_range(2*a))) - a;
   endfunction

   task automatic run_phase(string tag, int n, int vpct, bit tr_mode, int fa, int ga, bit junk, inout int k);
      for (int c = 0; c < n; c++) begin
         bit v, tr, sym;
         int j;
         @(negedge clk);
         v   = ($urandom_range(99) < vpct);
         tr  = tr_mode;
         sym = $urandom_range(1);
         for (int m = 0; m < NB; m++) begin
            int aa = (junk && !v) ? 32767 : fa;
            int bb = (junk && !v) ? 32767 : ga;
            fr[m] = rnd(aa); fi[m] = rnd(aa); gr[m] = rnd(bb); gi[m] = rnd(bb);
            bin_re[m*DW +: DW]  = DW'(fr[m]);
            bin_im[m*DW +: DW]  = DW'(fi[m]);
            nbin_re[m*DW +: DW] = DW'(gr[m]);
            nbin_im[m*DW +: DW] = DW'(gi[m]);
         end
         if (junk && !v) tr = $urandom_range(1);
         in_valid  = v;
         train_en  = tr;
         train_sym = sym;
         model_step(k, v, tr, sym);
         @(posedge clk);
         #(PER/4);
         j = k - LV;
         // R2: valid latency and output value
         check(out_valid == (j >= 0 && v_h[j]), "R2 valid", longint'(out_valid), longint'(j >= 0 && v_h[j]));
         if (j >= 0 && v_h[j]) begin
            check(longint'(eq_re) == y_re_h[j], tag, longint'(eq_re), y_re_h[j]);
            check(longint'(eq_im) == y_im_h[j], tag, longint'(eq_im), y_im_h[j]);
            check(det_sym == (y_re_h[j] < 0), "R4 slicer", longint'(det_sym), longint'(y_re_h[j] < 0));
         end
         k++;
      end
   endtask

   initial begin
      int k = 0;
      for (int m = 0; m < NB; m++) begin cm_re[m] = 0; cm_im[m] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
      check(eq_re == '0, "R1 re", longint'(eq_re), 0);
      check(eq_im == '0, "R1 im", longint'(eq_im), 0);
      rst_n = 1'b1;
      run_phase("R3 train",     300, 100, 1'b1,  4096,  512, 1'b0, k);
      run_phase("R5 sparse",    200,  25, 1'b1,  4096,  512, 1'b0, k);
      run_phase("R4 decide",    300, 100, 1'b0,  4096,  512, 1'b0, k);
      run_phase("R6 gaps",      200,  50, 1'b1,  4096,  512, 1'b1, k);
      run_phase("R7,R8 fullscale", 200, 100, 1'b1, 32767, 32767, 1'b0, k);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(PER*200000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R2 watchdog: actual %0d cycles expected completion", 200000);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule